// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat memory burst. A start strobe captures a full external address as the burst base. After that, each cycle in which the active-low advance input is asserted moves the burst on by one beat. The two low address bits then follow one of two orders: an interleaved order, where the low bits are the starting bits XOR the beat count, or a linear order, where the low bits are the starting bits plus the beat count, wrapping modulo four. The upper address bits always come from the captured base.

Either of two start strobes can open a burst, and a strobe wins over advance in the same cycle. When advance is inactive the burst is suspended and the address holds. A static order-select input picks the order. It is registered, so a change to it reaches the address one clock edge later. The outputs are the current full address and the beat index within the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `addr_o` is 0 and `beat_o` is 0. The registered order select resets to linear.
- R2: A rising clock edge with `start_a_i` or `start_b_i` high captures `addr_i`. After that edge, `addr_o` equals the captured address and `beat_o` is 0.
- R3: A start strobe takes priority over `adv_n_i` low in the same cycle. The burst restarts at beat 0 with the new address.
- R4: An edge with no start strobe and `adv_n_i` low increments `beat_o` by one. After beat 3 it wraps to beat 0.
- R5: An edge with no start strobe and `adv_n_i` high leaves `beat_o` unchanged. `addr_o` also holds while the order select is steady.
- R6: With the registered order select at 1 (interleaved), the low two bits of `addr_o` are the starting low bits XOR `beat_o`. From start 01 the order is 01,00,11,10, and from start 10 it is 10,11,00,01.
- R7: With the registered order select at 0 (linear), the low two bits of `addr_o` are (starting low bits + `beat_o`) mod 4. From start 01 the order is 01,10,11,00, and from start 11 it is 11,00,01,10.
- R8: Bits above bit 1 of `addr_o` equal the same bits of the captured address, whatever advance and the order select do.
- R9: `mode_i` is sampled on each rising edge. A change to it does not alter `addr_o` before the next edge, and after that edge it applies to the current beat.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_a_i | input | 1 | First burst start strobe, active high |
| start_b_i | input | 1 | Second burst start strobe, active high |
| addr_i | input | ADDR_W | External base address for a new burst |
| adv_n_i | input | 1 | Advance request, active low |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Beat index within the burst |

## Verification
A corrupt beat counter shows on `beat_o`, and also on the low address bits, in the cycle straight after the bad edge. That is because the address is a combinational mapping of registered state. A wrong captured base shows as a mismatch in the upper bits on every following beat. A wrong order map shows first on beat 1, where the interleaved and linear orders already differ for odd starting addresses. An order-select register that is skipped or doubled shows as the address changing one cycle early, or staying one cycle late, after a mode switch.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic { ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1 } order_t;

  function automatic logic [BEAT_W-1:0] low_bits_for(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input order_t            ord
  );
    logic [BEAT_W-1:0] r;
    if (ord == ORD_INTERLEAVE) r = start ^ beat;
    else                       r = start + beat;
    return r;
  endfunction
endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (restart) beat <= '0;
    else if (step)    beat <= beat + 1'b1;
  end
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mode_in,
  output logic [ADDR_W-1:0] base,
  output logic              mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_in;
      if (capture) base <= addr_in;
    end
  end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  logic              mode_q,
  output logic [ADDR_W-1:0] addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;
  order_t ord;
  assign ord = order_t'(mode_q);

  generate
    if (UPPER_W > 0) begin : g_upper
      assign addr = {base[ADDR_W-1:BEAT_W], low_bits_for(base[BEAT_W-1:0], beat, ord)};
    end else begin : g_low_only
      assign addr = low_bits_for(base[BEAT_W-1:0], beat, ord);
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_a_i,
  input  logic              start_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  // named internal events for the checker
  logic              load_ev;
  logic              step_ev;
  logic [ADDR_W-1:0] base_q;
  logic              mode_q;
  logic [BEAT_W-1:0] beat_q;

  assign load_ev = start_a_i | start_b_i;
  assign step_ev = ~adv_n_i;

  bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .capture(load_ev), .addr_in(addr_i),
    .mode_in(mode_i), .base(base_q), .mode_q(mode_q)
  );

  bsq_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(load_ev), .step(step_ev), .beat(beat_q)
  );

  bsq_order_map #(.ADDR_W(ADDR_W)) u_map (
    .base(base_q), .beat(beat_q), .mode_q(mode_q), .addr(addr_o)
  );

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_ev,
  input logic              adv_n_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_o,
  input logic [ADDR_W-1:0] base_q,
  input logic              mode_q
);
  p_load_captures_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_ev)) |-> (addr_o == $past(addr_i) && beat_o == 2'd0));

  p_load_over_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_ev) && !$past(adv_n_i)) |-> (beat_o == 2'd0));

  p_advance_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_ev) && !$past(adv_n_i)) |-> (beat_o == $past(beat_o) + 2'd1));

  p_suspend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_ev) && $past(adv_n_i)) |-> $stable(beat_o));

  p_interleave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> ((addr_o[1:0] ^ base_q[1:0]) == beat_o));

  p_linear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> ((addr_o[1:0] - base_q[1:0]) == beat_o));

  p_upper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_ev)) |-> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  p_mode_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mode_q == $past(mode_i)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .adv_n_i(adv_n_i),
  .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o),
  .base_q(base_q), .mode_q(mode_q)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_a_i = 1'b0, start_b_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adv_n_i = 1'b1;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_a_i(start_a_i), .start_b_i(start_b_i),
    .addr_i(addr_i), .adv_n_i(adv_n_i), .mode_i(mode_i),
    .addr_o(addr_o), .beat_o(beat_o)
  );

  // independent model: interleaved flips bits per beat, linear counts with wrap
  function automatic logic [1:0] want_low(int start, int beat, bit interleave);
    int v;
    if (interleave) v = ((start / 2 != (beat / 2) % 2 ? 1 : 0) * 2) + (start % 2 != beat % 2 ? 1 : 0);
    else            v = (start + beat) % 4;
    return v[1:0];
  endfunction

  task automatic chk(string req, logic [AW-1:0] got_a, logic [AW-1:0] exp_a,
                     logic [1:0] got_b, logic [1:0] exp_b);
    n_run++;
    if (got_a !== exp_a || got_b !== exp_b) begin
      n_fail++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d", req, got_a, got_b, exp_a, exp_b);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1", addr_o, '0, beat_o, 2'd0);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1", addr_o, '0, beat_o, 2'd0);
  endtask

  task automatic t_sequence(bit inter, logic [AW-1:0] base, bit use_b);
    mode_i = inter;
    addr_i = base;
    if (use_b) start_b_i = 1'b1; else start_a_i = 1'b1;
    tick();
    start_a_i = 1'b0; start_b_i = 1'b0; addr_i = '0;
    chk("R2", addr_o, base, beat_o, 2'd0);
    adv_n_i = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk(inter ? "R6 R8" : "R7 R8", addr_o,
          {base[AW-1:2], want_low(int'(base[1:0]), i % 4, inter)}, beat_o, 2'(i % 4));
    end
    adv_n_i = 1'b1;
  endtask

  task automatic t_suspend();
    logic [AW-1:0] base = 17'h0ABC5;
    mode_i = 1'b0; addr_i = base; start_a_i = 1'b1;
    tick();
    start_a_i = 1'b0; adv_n_i = 1'b0;
    tick();
    adv_n_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5", addr_o, {base[AW-1:2], 2'b10}, beat_o, 2'd1);
    end
    adv_n_i = 1'b0;
    tick();
    adv_n_i = 1'b1;
    chk("R4", addr_o, {base[AW-1:2], 2'b11}, beat_o, 2'd2);
  endtask

  task automatic t_priority();
    adv_n_i = 1'b0; mode_i = 1'b1; addr_i = 17'h00010; start_a_i = 1'b1;
    tick();
    tick();
    addr_i = 17'h1F00E; start_a_i = 1'b0; start_b_i = 1'b1;
    tick();
    start_b_i = 1'b0; adv_n_i = 1'b1;
    chk("R3", addr_o, 17'h1F00E, beat_o, 2'd0);
  endtask

  task automatic t_mode_latency();
    mode_i = 1'b0; addr_i = 17'h05551; start_a_i = 1'b1;
    tick();
    start_a_i = 1'b0; adv_n_i = 1'b0;
    tick();
    adv_n_i = 1'b1;
    chk("R9", addr_o, 17'h05552, beat_o, 2'd1);
    mode_i = 1'b1;
    #2;
    chk("R9", addr_o, 17'h05552, beat_o, 2'd1);
    tick();
    chk("R9", addr_o, 17'h05550, beat_o, 2'd1);
    mode_i = 1'b0;
    tick();
    chk("R9", addr_o, 17'h05552, beat_o, 2'd1);
  endtask

  initial begin
    t_reset();
    t_sequence(1'b1, 17'h12341, 1'b0);
    t_sequence(1'b1, 17'h00002, 1'b1);
    t_sequence(1'b0, 17'h1FFFD, 1'b1);
    t_sequence(1'b0, 17'h0C003, 1'b0);
    t_sequence(1'b1, 17'h0C003, 1'b0);
    t_sequence(1'b0, 17'h00000, 1'b1);
    t_suspend();
    t_priority();
    t_mode_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule